// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends a pair of 24-bit two's-complement audio samples, left then right, over one serial data line. It is a slave: an external bit clock and an external frame clock come in as plain inputs. Both are resampled into the fast system clock, and the block reacts to their edges there. Every bit of a word goes out after a falling edge of the bit clock, most significant bit first, so a receiver can capture it on the rising edge.

One static input picks the framing. With MSB-justified framing the first data bit comes with the frame-clock transition, and a high frame clock marks the left slot. With I2S framing the first data bit comes one bit clock after the transition, and a low frame clock marks the left slot. The block counts the bit clocks in each slot and takes the frame rate from that count: a 16-clock slot (32 per frame) carries the upper 16 bits of the sample, and 24- or 32-clock slots carry all 24 bits. Any spare bits in a slot go out as zero.

A new sample pair is captured when each left slot begins. While the power-down input is high, the data line is held low and the framing state is cleared.

Top module: `stereo_ser_tx`

## Requirements
- R1: With `fmtI2s` = 0 (MSB-justified), the word's MSB is driven in the bit clock whose falling edge carries the frame-clock transition, and a high `lrckIn` marks the left slot.
- R2: With `fmtI2s` = 1 (I2S), the word's MSB is driven one bit clock after the frame-clock transition, and a low `lrckIn` marks the left slot; the bit driven at the transition itself is the previous word's LSB when that word fills its slot, otherwise zero.
- R3: `sdOut` changes only in response to a falling edge of `sclkIn` (or to power-down); it stays constant while `sclkIn` is high.
- R4: Each frame carries the left sample, then the right sample, MSB first, in two's complement.
- R5: When the previous slot had 16 bit clocks, a slot carries sample bits 23 down to 8 (16 bits); when it had 24 or 32 bit clocks, it carries bits 23 down to 0.
- R6: The bit clocks after a word's LSB, up to the next frame-clock transition, drive zero.
- R7: Both samples are captured at the start of the left slot; a change of `rightSample` during the left slot does not affect the right word of that frame and appears in the next frame.
- R8: While `pwrDown` is high, `sdOut` is low in the same cycle, whatever the clocks and samples are doing; after release, correct frames resume.
- R9: After reset `sdOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDown | input | 1 | High forces the output low and clears the framing state |
| fmtI2s | input | 1 | 0 selects MSB-justified framing, 1 selects I2S framing |
| sclkIn | input | 1 | External bit clock |
| lrckIn | input | 1 | External frame clock |
| leftSample | input | 24 | Left-channel sample, two's complement |
| rightSample | input | 24 | Right-channel sample, two's complement |
| sdOut | output | 1 | Serial data line |

## Verification
A wrong slot-edge decision shifts the whole word by one bit position. A wrong channel decision puts the other sample's bits in the slot, and both errors show up in the first slot that follows. A wrong measured slot length shows one frame later: either eight bits of the low byte are missing or extra bits appear where zeros are expected. A wrong capture point for the right sample appears as a value from the wrong frame. Every frame is therefore compared bit by bit across each whole slot, with the frame rate changing from one stimulus set to the next.

// File: rtl/stereo_ser_tx_pkg.sv
package stereo_ser_tx_pkg;

  // Strobes from the framing control to the datapath, valid for one system cycle.
  typedef struct packed {
    logic bitTick;    // a falling bit-clock edge was seen
    logic slotStart;  // this tick also begins a new slot
    logic leftSlot;   // the slot in progress is the left channel
    logic shortWord;  // previous slot was short: send the truncated word
  } txStrobe_t;

endpackage

// File: rtl/stereo_ser_tx_sync.sv
module stereo_ser_tx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= '0;
          else       stage[g] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= '0;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/stereo_ser_tx_ctrl.sv
module stereo_ser_tx_ctrl
  import stereo_ser_tx_pkg::*;
#(
  parameter int SHORT_W  = 16,
  parameter int MAX_SLOT = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwrDown,
  input  logic      fmtI2s,
  input  logic      sclkSync,
  input  logic      lrckSync,
  output txStrobe_t strb
);

  localparam int CNT_W = $clog2(MAX_SLOT + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_W);

  logic             sclkPrev;
  logic             lrPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] slotLen;
  logic             tick;
  logic             edgeSeen;

  assign tick     = sclkPrev & ~sclkSync & ~pwrDown;
  assign edgeSeen = tick & (lrckSync != lrPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrPrev  <= 1'b0;
      bitCnt  <= '0;
      slotLen <= '0;
    end else if (pwrDown) begin
      lrPrev  <= 1'b0;
      bitCnt  <= '0;
      slotLen <= '0;
    end else if (tick) begin
      lrPrev <= lrckSync;
      if (edgeSeen) begin
        bitCnt  <= '0;
        slotLen <= (bitCnt == CNT_MAX) ? CNT_MAX : bitCnt + 1'b1;
      end else if (bitCnt != CNT_MAX) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.bitTick   = tick;
    strb.slotStart = edgeSeen;
    strb.leftSlot  = fmtI2s ? ~lrckSync : lrckSync;
    strb.shortWord = (slotLen != '0) && (slotLen <= SHORT_LEN);
  end

endmodule

// File: rtl/stereo_ser_tx_data.sv
module stereo_ser_tx_data
  import stereo_ser_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrDown,
  input  logic                fmtI2s,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  txStrobe_t           strb,
  output logic                sdOut
);

  localparam int DROP_W = SAMPLE_W - SHORT_W;

  logic [SAMPLE_W-1:0] rightHeld;
  logic [SAMPLE_W-1:0] shReg;
  logic [SAMPLE_W-1:0] rawWord;
  logic [SAMPLE_W-1:0] slotWord;
  logic                sdReg;

  assign rawWord = strb.leftSlot ? leftSample : rightHeld;

  generate
    if (DROP_W > 0) begin : g_trunc
      assign slotWord = strb.shortWord
                        ? {rawWord[SAMPLE_W-1:DROP_W], {DROP_W{1'b0}}}
                        : rawWord;
    end else begin : g_full
      assign slotWord = rawWord;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rightHeld <= '0;
      shReg     <= '0;
      sdReg     <= 1'b0;
    end else if (pwrDown) begin
      shReg <= '0;
      sdReg <= 1'b0;
    end else if (strb.bitTick) begin
      if (strb.slotStart) begin
        if (fmtI2s) begin
          sdReg <= shReg[SAMPLE_W-1];
          shReg <= slotWord;
        end else begin
          sdReg <= slotWord[SAMPLE_W-1];
          shReg <= {slotWord[SAMPLE_W-2:0], 1'b0};
        end
        if (strb.leftSlot) rightHeld <= rightSample;
      end else begin
        sdReg <= shReg[SAMPLE_W-1];
        shReg <= {shReg[SAMPLE_W-2:0], 1'b0};
      end
    end
  end

  assign sdOut = sdReg & ~pwrDown;

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import stereo_ser_tx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SHORT_W     = 16,
  parameter int MAX_SLOT    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrDown,
  input  logic                fmtI2s,
  input  logic                sclkIn,
  input  logic                lrckIn,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                sdOut
);

  logic [1:0] clkPair;
  txStrobe_t  strb;

  stereo_ser_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({lrckIn, sclkIn}),
    .dOut (clkPair)
  );

  stereo_ser_tx_ctrl #(.SHORT_W(SHORT_W), .MAX_SLOT(MAX_SLOT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwrDown  (pwrDown),
    .fmtI2s   (fmtI2s),
    .sclkSync (clkPair[0]),
    .lrckSync (clkPair[1]),
    .strb     (strb)
  );

  stereo_ser_tx_data #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .pwrDown     (pwrDown),
    .fmtI2s      (fmtI2s),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .strb        (strb),
    .sdOut       (sdOut)
  );

endmodule

// File: rtl/stereo_ser_tx_chk.sv
module stereo_ser_tx_chk
  import stereo_ser_tx_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      pwrDown,
  input logic      fmtI2s,
  input logic      leftMsb,
  input logic      sdOut,
  input txStrobe_t strb
);

  AST_PD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> !sdOut) else $error("power-down output not low"); // R8

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.bitTick && !pwrDown) |=> ($stable(sdOut) || pwrDown))
    else $error("output moved without a bit-clock fall"); // R3

  AST_SLOT_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotStart |-> strb.bitTick) else $error("slot start off a tick"); // R1

  AST_MSBJ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (!fmtI2s && strb.slotStart && strb.leftSlot && !pwrDown)
    |=> (sdOut == $past(leftMsb) || pwrDown))
    else $error("left MSB not at transition"); // R1

  AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !sdOut) else $error("output not low after reset"); // R9

endmodule

bind stereo_ser_tx stereo_ser_tx_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pwrDown (pwrDown),
  .fmtI2s  (fmtI2s),
  .leftMsb (leftSample[SAMPLE_W-1]),
  .sdOut   (sdOut),
  .strb    (strb)
);

// File: tb/stereo_ser_tx_tb.sv
module stereo_ser_tx_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pwrDown;
  logic        fmtI2s;
  logic        sclkIn;
  logic        lrckIn;
  logic [23:0] leftSample;
  logic [23:0] rightSample;
  logic        sdOut;

  int nChecks = 0;
  int nFails  = 0;
  int stableErr = 0;
  bit midEn = 0;
  int midBit = 0;
  logic [23:0] midRight = '0;

  always #5 clk = ~clk;

  stereo_ser_tx u_dut (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .fmtI2s(fmtI2s),
    .sclkIn(sclkIn), .lrckIn(lrckIn),
    .leftSample(leftSample), .rightSample(rightSample), .sdOut(sdOut)
  );

  // {fmt, rate select (0:16-clock slot, 1:24, 2:32), left, right}
  localparam logic [50:0] VEC [8] = '{
    {1'b0, 2'd2, 24'h123456, 24'hABCDEF},
    {1'b0, 2'd1, 24'h800000, 24'h7FFFFF},
    {1'b0, 2'd0, 24'hA5C3F0, 24'h5A3C0F},
    {1'b1, 2'd2, 24'h123456, 24'hABCDEF},
    {1'b1, 2'd1, 24'h000001, 24'hFFFFFE},
    {1'b1, 2'd0, 24'hC0FFEE, 24'h135799},
    {1'b0, 2'd1, 24'hFFFFFF, 24'h000000},
    {1'b1, 2'd2, 24'h800001, 24'h7FFFFE}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bitClock(input logic lr, output logic b);
    logic b2;
    @(negedge clk);
    sclkIn = 1'b0;
    lrckIn = lr;
    repeat (8) @(negedge clk);
    sclkIn = 1'b1;
    #1;
    b = sdOut;
    repeat (7) @(negedge clk);
    b2 = sdOut;
    if (b2 !== b) stableErr++;
  endtask

  task automatic runFrame(input bit i2s, input int slot,
                          output logic [31:0] capL, output logic [31:0] capR);
    logic b;
    capL = '0;
    capR = '0;
    for (int k = 0; k < slot; k++) begin
      if (midEn && k == midBit) rightSample = midRight;
      bitClock(i2s ? 1'b0 : 1'b1, b);
      capL[31-k] = b;
    end
    for (int k = 0; k < slot; k++) begin
      bitClock(i2s ? 1'b1 : 1'b0, b);
      capR[31-k] = b;
    end
  endtask

  function automatic logic [31:0] expSlot(input bit i2s, input int slot,
                                          input logic [23:0] w, input logic [23:0] prev);
    logic [31:0] e;
    int effW;
    e = '0;
    effW = (slot == 16) ? 16 : 24;
    for (int k = 0; k < slot; k++) begin
      int j;
      logic bv;
      j = i2s ? k - 1 : k;
      if (j < 0) bv = (slot == effW) ? prev[24-effW] : 1'b0;
      else       bv = (j < effW) ? w[23-j] : 1'b0;
      e[31-k] = bv;
    end
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] capL, capR;
    logic b;
    rstN = 1'b0; pwrDown = 1'b0; fmtI2s = 1'b0;
    sclkIn = 1'b1; lrckIn = 1'b0;
    leftSample = '0; rightSample = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset output", {31'b0, sdOut}, 32'h0);

    // Table walk: three frames per vector, the last one is compared.
    for (int v = 0; v < 8; v++) begin
      bit i2s;
      int slot;
      string tag;
      i2s = VEC[v][50];
      slot = (VEC[v][49:48] == 2'd0) ? 16 : (VEC[v][49:48] == 2'd1) ? 24 : 32;
      fmtI2s = i2s;
      leftSample = VEC[v][47:24];
      rightSample = VEC[v][23:0];
      for (int f = 0; f < 3; f++) runFrame(i2s, slot, capL, capR);
      tag = $sformatf("%s R4 %s vec%0d", i2s ? "R2" : "R1",
                      (slot == 16) ? "R5" : (slot == 32) ? "R6" : "R5full", v);
      check({tag, " left"},  capL, expSlot(i2s, slot, VEC[v][47:24], VEC[v][23:0]));
      check({tag, " right"}, capR, expSlot(i2s, slot, VEC[v][23:0], VEC[v][47:24]));
    end

    check("R3 stable while bit clock high", stableErr, 0);

    // R7: right sample changed in the middle of the left slot.
    fmtI2s = 1'b0;
    leftSample = 24'h111111;
    rightSample = 24'h222222;
    for (int f = 0; f < 2; f++) runFrame(1'b0, 24, capL, capR);
    midEn = 1'b1; midBit = 4; midRight = 24'h333333;
    runFrame(1'b0, 24, capL, capR);
    midEn = 1'b0;
    check("R7 right word of current frame", capR, expSlot(1'b0, 24, 24'h222222, 24'h111111));
    runFrame(1'b0, 24, capL, capR);
    check("R7 right word of next frame", capR, expSlot(1'b0, 24, 24'h333333, 24'h111111));

    // R8: power-down while the line is high.
    leftSample = 24'hFFFFFF;
    runFrame(1'b0, 24, capL, capR);
    for (int k = 0; k < 3; k++) bitClock(1'b1, b);
    check("R4 line high before power-down", {31'b0, b}, 32'h1);
    @(negedge clk);
    pwrDown = 1'b1;
    #1;
    check("R8 low at once", {31'b0, sdOut}, 32'h0);
    runFrame(1'b0, 24, capL, capR);
    check("R8 left slot during power-down", capL, 32'h0);
    check("R8 right slot during power-down", capR, 32'h0);
    pwrDown = 1'b0;
    rightSample = 24'h0F0F0F;
    for (int f = 0; f < 3; f++) runFrame(1'b0, 24, capL, capR);
    check("R8 left after release", capL, expSlot(1'b0, 24, 24'hFFFFFF, 24'h0F0F0F));
    check("R8 right after release", capR, expSlot(1'b0, 24, 24'h0F0F0F, 24'hFFFFFF));

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule